// File: doc/BRIEF.md
# Platform Reset Control Port

This block is a single byte-wide register in I/O space at address 0xCF9. Software uses it to ask for a platform reset and to choose what kind of reset that will be. A write with the trigger bit set starts a reset request. A write without the trigger bit records the reset-type bit. A read at the same address returns the recorded value.

The reset request leaves the block as a pulse of a fixed, parameterised length. A downstream reset sequencer samples it. The recorded type bit is exported on its own pin, so the sequencer can choose a warm or a cold sequence. This block does not sequence the reset of the rest of the system.

Top module: `rst_ctl_port`

## Requirements
- R1: Only accesses whose address equals PORT_ADDR (default 0xCF9) are decoded. A write to any other address leaves the stored value unchanged. A read at any other address gives `io_rdata` = 0 and `io_rvalid` = 0.
- R2: A decoded write with bit 2 of the data set requests a reset. The stored value stays as it was.
- R3: A decoded write with bit 2 clear stores the written bit 1 at bit position 1 and forces every other stored bit to 0. The new value is visible from the next cycle.
- R4: A decoded read drives the stored byte on `io_rdata` and raises `io_rvalid` in the same cycle, with no wait state.
- R5: Reset clears the stored value to 0x00 and holds `sys_rst_req` low.
- R6: After an accepted trigger write, `sys_rst_req` goes high in the next cycle. It stays high for exactly PULSE_CYCLES consecutive cycles.
- R7: A trigger write that arrives while `sys_rst_req` is high is ignored. The pulse is neither restarted nor lengthened.
- R8: `rst_type` always equals bit 1 of the stored value.
- R9: When a decoded read and a decoded write happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data; zero unless a decoded read is under way |
| io_rvalid | output | 1 | High while this block answers a read |
| sys_rst_req | output | 1 | Stretched reset request pulse |
| rst_type | output | 1 | Stored reset-type selection |

## Verification
The bench goes after these corner cases:
- Trigger writes with bit 1 set and with bit 1 clear. A design that stored the trigger byte would report a changed type.
- A byte with all bits set except the trigger. A register that kept more than the type bit would read back extra ones.
- A second trigger inside a running pulse. If the counter reloaded on it, the pulse would be longer than PULSE_CYCLES, and the bench counts its length to catch this.
- Neighbouring addresses and a read that shares its cycle with a write. These expose sloppy decoding and read data that comes from the new value instead of the old one.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned TRIG_POS = 2;
  localparam int unsigned TYPE_POS = 1;

  // Bits of a written byte that survive into the register.
  function automatic logic [DATA_W-1:0] keep_bits(input logic [DATA_W-1:0] wdata);
    logic [DATA_W-1:0] res;
    res = '0;
    res[TYPE_POS] = wdata[TYPE_POS];
    return res;
  endfunction

  function automatic logic is_trigger(input logic [DATA_W-1:0] wdata);
    return wdata[TRIG_POS];
  endfunction

endpackage

// File: rtl/rcp_decode.sv
module rcp_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;

  assign addr_match = (io_addr == PORT_ADDR);
  assign wr_hit     = io_wr && addr_match;
  assign rd_hit     = io_rd && addr_match;
endmodule

// File: rtl/rcp_store.sv
module rcp_store
  import rcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              fire,
  output logic [DATA_W-1:0] stored
);
  logic store_en;

  assign fire     = wr_hit && is_trigger(io_wdata);
  assign store_en = wr_hit && !is_trigger(io_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stored <= '0;
    else if (store_en) stored <= keep_bits(io_wdata);
  end

  // R2: a trigger write leaves the register as it was
  assert_trigger_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $stable(stored));

  // R3: a plain write keeps only the type bit
  assert_plain_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> (stored[TYPE_POS] == $past(io_wdata[TYPE_POS])) &&
                 ($countones(stored) == {31'd0, stored[TYPE_POS]}));

  // R5: reset clears the register
  assert_reset_clear_R5: assert property (@(posedge clk)
    !rst_n |=> (stored == '0));
endmodule

// File: rtl/rcp_stretch.sv
module rcp_stretch #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic fire_taken
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt;

  assign busy       = (cnt != '0);
  assign fire_taken = fire && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire_taken) cnt <= LOAD;
    else if (busy)       cnt <= cnt - CNT_W'(1);
  end

  // R6: an accepted trigger starts a full-length pulse next cycle
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_taken |=> busy && (cnt == LOAD));

  // R7: a trigger during the pulse does not reload the count
  assert_no_extend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R5: no request while held in reset
  assert_reset_idle_R5: assert property (@(posedge clk)
    !rst_n |=> !busy);
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rcp_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              sys_rst_req,
  output logic              rst_type
);
  logic              wr_hit;
  logic              rd_hit;
  logic              fire;
  logic              fire_taken;
  logic              busy;
  logic [DATA_W-1:0] stored;

  rcp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  rcp_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .io_wdata (io_wdata),
    .fire     (fire),
    .stored   (stored)
  );

  rcp_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .busy       (busy),
    .fire_taken (fire_taken)
  );

  assign io_rdata    = rd_hit ? stored : '0;
  assign io_rvalid   = rd_hit;
  assign sys_rst_req = busy;
  assign rst_type    = stored[TYPE_POS];

  // R1: writes elsewhere leave the register alone
  assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr != PORT_ADDR)) |=> $stable(stored));

  // R8: the exported type agrees with what a read returns
  assert_type_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> (rst_type == io_rdata[TYPE_POS]));

  // R6: the request only rises after an accepted trigger
  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(fire_taken));
endmodule

// File: tb/test_rst_ctl_port.sv
module test_rst_ctl_port;
  localparam int P = 6;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        sys_rst_req;
  logic        rst_type;

  int errors = 0;
  int checks = 0;
  int m_store = 0;
  int m_cnt = 0;
  int req_hits = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rst_ctl_port #(.ADDR_W(16), .PORT_ADDR(PORT), .PULSE_CYCLES(P)) i_rst_ctl_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .sys_rst_req(sys_rst_req), .rst_type(rst_type)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare before the rising
  // edge, then advance the reference model.
  task automatic cycle(input logic [15:0] a, input bit wr, input bit rd, input logic [7:0] d);
    bit hit;
    @(negedge clk);
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
    #2;
    hit = (a == PORT);
    chk("R4/R1/R9 rdata", int'(io_rdata), (hit && rd) ? m_store : 0);
    chk("R4/R1 rvalid", int'(io_rvalid), (hit && rd) ? 1 : 0);
    chk("R6/R7 request", int'(sys_rst_req), (m_cnt != 0) ? 1 : 0);
    chk("R8 type", int'(rst_type), (m_store >> 1) & 1);
    if (sys_rst_req) req_hits++;
    @(posedge clk);
    if (hit && wr && d[2]) begin
      if (m_cnt == 0) m_cnt = P;
      else m_cnt = m_cnt - 1;
    end else begin
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (hit && wr) m_store = int'(d) & 2;
    end
  endtask

  task automatic rd_expect(input string req, input int exp);
    cycle(PORT, 1'b0, 1'b1, 8'h00);
    chk(req, int'(io_rdata), exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R5 request in reset", int'(sys_rst_req), 0);
    @(negedge clk);
    rst_n = 1'b1;

    rd_expect("R5 reset value", 0);

    cycle(PORT, 1'b1, 1'b0, 8'hFB);
    rd_expect("R3 only type bit kept", 2);

    // trigger with bit 1 clear must not change the stored type
    req_hits = 0;
    cycle(PORT, 1'b1, 1'b0, 8'h04);
    rd_expect("R2 stored unchanged by trigger", 2);
    repeat (P + 2) cycle(16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R6 pulse length", req_hits, P);

    // second trigger inside the pulse
    req_hits = 0;
    cycle(PORT, 1'b1, 1'b0, 8'h06);
    cycle(16'h0000, 1'b0, 1'b0, 8'h00);
    cycle(PORT, 1'b1, 1'b0, 8'h04);
    repeat (P + 2) cycle(16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R7 no extension", req_hits, P);

    cycle(16'hCF8, 1'b1, 1'b0, 8'h00);
    cycle(16'hCFA, 1'b1, 1'b0, 8'h04);
    chk("R1 no request from miss", int'(sys_rst_req), 0);
    cycle(16'hCF8, 1'b0, 1'b1, 8'h00);
    chk("R1 miss read zero", int'(io_rdata), 0);
    rd_expect("R1 value kept", 2);

    cycle(PORT, 1'b1, 1'b0, 8'h00);
    #1 chk("R8 type cleared", int'(rst_type), 0);
    cycle(PORT, 1'b1, 1'b1, 8'h02);
    chk("R9 old value on same-cycle read", int'(io_rdata), 0);
    rd_expect("R9 new value after", 2);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel < 2) ? PORT : (sel == 2) ? 16'hCF8 : 16'($urandom);
      cycle(a, 1'($urandom), 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule